// File: doc/BRIEF.md
# Predicated Sign-Extending Halfword Gather Unit

This block performs one predicated vector gather. A start pulse captures a vector of 64-bit base addresses, one enable bit per lane and a 5-bit scaled offset. The block then visits the enabled lanes one at a time, from the lowest lane index upward. For each enabled lane it issues a single 16-bit read on a valid/ready memory port and writes the returned halfword into that lane's 64-bit result, sign-extended. Lanes that are not enabled cost no memory cycle. Their results read as zero.

When every lane has been handled, the block pulses `done` and holds the result vector. An odd lane address, or a response flagged as an error, halts the walk instead. In that case the block raises `fault` and reports the offending lane. The vector width `VLEN` may be 128, 256, 512, 1024 or 2048 bits, which gives `VLEN/64` lanes. Lane i occupies bits `[64*i+63 : 64*i]` of both `base_vec` and `result`, and `pred[i]` enables lane i.

Top module: `gather_sx16`

## Requirements
- R1: The result lane of each enabled lane whose read completes without error equals the 16-bit response data sign-extended to 64 bits: bit 15 is copied into bits 63..16.
- R2: The read address for an enabled lane is that lane's base plus `2*imm5`, computed modulo 2^64, where `imm5` is an unsigned value from 0 to 31.
- R3: A lane whose `pred` bit is 0 issues no read and never faults, even when its base is odd. Its result lane is zero.
- R4: Reads are issued in ascending lane order. No new request is raised until the response to the previous one has arrived.
- R5: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_addr` stays unchanged on the following cycle.
- R6: An enabled lane with an odd address issues no request. It sets `fault` and sets `fault_lane` to that lane's index.
- R7: A response with `rsp_err` high sets `fault` and sets `fault_lane` to the current lane. Lanes already completed keep their values, and every later lane reads zero. No further requests follow, and `done` is not pulsed.
- R8: On success, `done` is high for exactly one cycle. `result` then holds its value until the next accepted start.
- R9: When all `pred` bits are 0, `done` is high in the cycle that follows the second rising edge counted from the edge that samples `start`. No request is issued.
- R10: A `start` that arrives while `busy` is high has no effect on the operation in progress or on its result.
- R11: A synchronous reset (`rst` high at a rising edge) returns the block to idle with `result` zero and `busy`, `done` and `fault` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins an operation; accepted only when idle |
| base_vec | input | VLEN | Per-lane 64-bit base addresses |
| pred | input | VLEN/64 | Per-lane enable |
| imm5 | input | 5 | Offset in halfwords; byte offset is twice this value |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 64 | Byte address of the halfword to read |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 16 | Returned halfword |
| rsp_err | input | 1 | Response reports an error |
| result | output | VLEN | Per-lane 64-bit sign-extended results |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| fault | output | 1 | Operation stopped on a fault; held until the next start |
| fault_lane | output | max(1, clog2(VLEN/64)) | Index of the lane that faulted |

## Verification
The bench builds the block with `VLEN` = 256, which gives four lanes. At that size every one of the 16 predicate patterns can be swept, each crossed with the offsets 0, 1, 17 and 31. Expected addresses and sign-extended results are computed arithmetically from a formula-based memory model. The responder stalls `req_ready` and delays responses in a pseudo-random pattern. Four lanes are enough to place an odd base or an error response on a first, middle or last enabled lane. They are also enough to place an odd base on a lane that is disabled.

// File: rtl/gather_sx16.sv
module gather_sx16 #(
  parameter int VLEN  = 256,
  localparam int LANES = VLEN / 64,
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VLEN-1:0]   base_vec,
  input  logic [LANES-1:0]  pred,
  input  logic [4:0]        imm5,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [63:0]       req_addr,
  input  logic              rsp_valid,
  input  logic [15:0]       rsp_data,
  input  logic              rsp_err,
  output logic [VLEN-1:0]   result,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [LW-1:0]     fault_lane
);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_REQ, S_RSP} st_t;

  st_t              st;
  logic [63:0]      base_q [LANES];
  logic [LANES-1:0] pend;
  logic [5:0]       off_q;
  logic [LW-1:0]    cur;
  logic [63:0]      addr_q;
  logic [LW-1:0]    nxt;
  logic [63:0]      nxt_addr;

  always_comb begin
    nxt = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (pend[i]) nxt = LW'(i);
  end

  assign nxt_addr  = base_q[nxt] + {58'd0, off_q};
  assign req_valid = (st == S_REQ);
  assign req_addr  = addr_q;
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      pend       <= '0;
      off_q      <= '0;
      cur        <= '0;
      addr_q     <= '0;
      result     <= '0;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_lane <= '0;
      for (int i = 0; i < LANES; i++) base_q[i] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          for (int i = 0; i < LANES; i++) base_q[i] <= base_vec[64*i +: 64];
          pend   <= pred;
          off_q  <= {imm5, 1'b0};
          result <= '0;
          fault  <= 1'b0;
          st     <= S_SCAN;
        end
        S_SCAN: begin
          if (pend == '0) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (nxt_addr[0]) begin
            fault      <= 1'b1;
            fault_lane <= nxt;
            st         <= S_IDLE;
          end else begin
            cur    <= nxt;
            addr_q <= nxt_addr;
            st     <= S_REQ;
          end
        end
        S_REQ: if (req_ready) st <= S_RSP;
        S_RSP: if (rsp_valid) begin
          if (rsp_err) begin
            fault      <= 1'b1;
            fault_lane <= cur;
            st         <= S_IDLE;
          end else begin
            for (int i = 0; i < LANES; i++)
              if (cur == LW'(i)) result[64*i +: 64] <= {{48{rsp_data[15]}}, rsp_data};
            pend[cur] <= 1'b0;
            st        <= S_SCAN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R5
  AST_REQ_EVEN: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !req_addr[0]); // R6
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_valid); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> $stable(result)); // R8
  AST_DONE_NOT_FAULT: assert property (@(posedge clk) disable iff (rst)
    done |-> !fault); // R7

endmodule

// File: tb/gather_sx16_tb.sv
module gather_sx16_tb;
  localparam int VLEN = 256;
  localparam int LANES = VLEN / 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [VLEN-1:0] base_vec = '0;
  logic [LANES-1:0] pred = '0;
  logic [4:0] imm5 = '0;
  logic req_valid, req_ready = 1'b0;
  logic [63:0] req_addr;
  logic rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [15:0] rsp_data = '0;
  logic [VLEN-1:0] result;
  logic busy, done, fault;
  logic [1:0] fault_lane;

  gather_sx16 #(.VLEN(VLEN)) u_dut (
    .clk(clk), .rst(rst), .start(start), .base_vec(base_vec), .pred(pred), .imm5(imm5),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .result(result), .busy(busy), .done(done), .fault(fault), .fault_lane(fault_lane));

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  int exp_n = 0, got_n = 0;
  logic [63:0] exp_addr [LANES];
  logic [63:0] err_addr = '0;
  bit err_en = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] memf(input logic [63:0] a);
    return a[16:1] * 16'h6F1D ^ a[47:32];
  endfunction

  initial begin : responder
    logic [15:0] lf = 16'hACE1;
    bit pend_rsp = 1'b0, prev_wait = 1'b0;
    logic [63:0] prev_addr = '0, hs_addr = '0;
    int dly = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      rsp_err = 1'b0;
      if (rst) begin
        pend_rsp = 1'b0; prev_wait = 1'b0; req_ready = 1'b0;
        continue;
      end
      if (prev_wait) chk(req_valid && req_addr == prev_addr, "R5", 256'(req_addr), 256'(prev_addr));
      if (pend_rsp && req_valid) chk(1'b0, "R4", 256'(req_addr), 256'(0));
      if (pend_rsp) begin
        if (dly == 0) begin
          rsp_valid = 1'b1;
          rsp_data = memf(hs_addr);
          rsp_err = err_en && hs_addr == err_addr;
          pend_rsp = 1'b0;
        end else dly--;
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      req_ready = lf[0] | lf[1];
      prev_wait = req_valid && !req_ready;
      prev_addr = req_addr;
      if (req_valid && req_ready) begin
        if (got_n < exp_n) chk(req_addr == exp_addr[got_n], "R2", 256'(req_addr), 256'(exp_addr[got_n]));
        else chk(1'b0, "R3", 256'(got_n), 256'(exp_n));
        got_n++;
        hs_addr = req_addr;
        pend_rsp = 1'b1;
        dly = int'(lf[3:2]) % 3;
      end
    end
  end

  task automatic run_case(input logic [VLEN-1:0] b, input logic [LANES-1:0] p, input logic [4:0] im,
                          input int errl, input bit poke);
    logic [VLEN-1:0] eres = '0;
    bit efault = 1'b0, stop = 1'b0;
    int efl = 0, cyc = 0;
    logic [VLEN-1:0] snap;
    exp_n = 0;
    err_en = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      logic [63:0] a;
      a = b[64*i +: 64] + 64'({im, 1'b0});
      if (!stop && p[i]) begin
        if (a[0]) begin efault = 1'b1; efl = i; stop = 1'b1; end
        else begin
          exp_addr[exp_n] = a; exp_n++;
          if (i == errl) begin efault = 1'b1; efl = i; stop = 1'b1; err_en = 1'b1; err_addr = a; end
          else eres[64*i +: 64] = {{48{memf(a)[15]}}, memf(a)};
        end
      end
    end
    got_n = 0;
    @(negedge clk);
    start = 1'b1; base_vec = b; pred = p; imm5 = im;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk); @(negedge clk);
      start = 1'b1; pred = '0; base_vec = ~b; imm5 = ~im;
      @(negedge clk);
      start = 1'b0;
    end
    while (!(done || fault) && cyc < 400) begin @(negedge clk); cyc++; end
    if (p == '0) begin
      chk(cyc == 1, "R9", 256'(cyc), 256'(1));
      chk(got_n == 0, "R9", 256'(got_n), 256'(0));
    end
    chk(done == !efault, poke ? "R10" : (efault ? "R7" : "R8"), 256'(done), 256'(!efault));
    chk(fault == efault, efault ? "R6" : "R3", 256'(fault), 256'(efault));
    if (efault) chk(fault_lane == 2'(efl), "R6", 256'(fault_lane), 256'(efl));
    chk(result == eres, efault ? "R7" : (poke ? "R10" : "R1"), result, eres);
    chk(got_n == exp_n, "R4", 256'(got_n), 256'(exp_n));
    snap = result;
    @(negedge clk);
    chk(!done, "R8", 256'(done), 256'(0));
    @(negedge clk); @(negedge clk);
    chk(result == snap && got_n == exp_n, "R8", result, snap);
    err_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin : main
    logic [VLEN-1:0] b;
    logic [4:0] imms [4];
    imms = '{5'd0, 5'd1, 5'd17, 5'd31};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(result == '0 && !busy && !done && !fault && !req_valid, "R11", result, '0);

    for (int p = 0; p < 16; p++)
      for (int k = 0; k < 4; k++) begin
        for (int i = 0; i < LANES; i++)
          b[64*i +: 64] = (64'h8000_1234_0000_0000 ^ (64'(i) * 64'h0101_0000_2468)
                          + 64'(p) * 64'h40 + 64'(k) * 64'h1_0000 + 64'(i) * 64'h7FFF_0000) & ~64'd1;
        run_case(b, 4'(p), imms[k], -1, 1'b0);
      end

    b[64*2 +: 64] = b[64*2 +: 64] | 64'd1;
    run_case(b, 4'hB, 5'd3, -1, 1'b0);
    run_case(b, 4'hF, 5'd3, -1, 1'b0);
    run_case(b, 4'h4, 5'd9, -1, 1'b0);
    b[64*2 +: 64] = b[64*2 +: 64] & ~64'd1;
    b[64*0 +: 64] = b[64*0 +: 64] | 64'd1;
    run_case(b, 4'hF, 5'd0, -1, 1'b0);
    run_case(b, 4'hE, 5'd0, -1, 1'b0);
    b[64*0 +: 64] = b[64*0 +: 64] & ~64'd1;

    run_case(b, 4'hF, 5'd5, 1, 1'b0);
    run_case(b, 4'hF, 5'd5, 0, 1'b0);
    run_case(b, 4'h8, 5'd30, 3, 1'b0);
    run_case(b, 4'hD, 5'd12, 1, 1'b0);
    run_case(b, 4'hF, 5'd7, -1, 1'b0);

    run_case(b, 4'hF, 5'd2, -1, 1'b1);
    run_case(b, 4'h5, 5'd21, -1, 1'b1);

    @(negedge clk);
    start = 1'b1; base_vec = b; pred = 4'hF; imm5 = 5'd4;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(result == '0 && !busy && !done && !fault, "R11", result, '0);
    @(negedge clk);
    chk(!req_valid && !busy, "R11", 256'(req_valid), 256'(0));
    exp_n = 0;
    run_case(b, 4'h9, 5'd11, -1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule